// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a memory address from up to three terms: an optional base register value, an optional index register value multiplied by a power-of-two scale, and a signed displacement. The sum wraps modulo 2^ADDR_W. A request also carries an operation kind. An address-only request turns the sum into a register write-back for a destination register and touches no memory. A memory-access request turns the sum into a read or write request, tagged with an operand width of one, two or four bytes.

Requests arrive on a valid/ready input. The result sits in a single output register that holds it until the consumer accepts it. Two kinds of request are refused: a memory access that names a second memory operand, and a memory access with a reserved width code. A refused request still produces one output beat. That beat carries an illegal flag and no register write and no memory request.

Top module: `ea_gen`

## Requirements
- R1: When `out_valid` is high, `out_addr` equals base term + index term × scale + `in_disp` of the accepted request, truncated to ADDR_W bits (wraparound, no overflow flag).
- R2: `in_scale` selects the index multiplier: 2'b00 = 1, 2'b01 = 2, 2'b10 = 4, 2'b11 = 8.
- R3: `in_disp` is two's complement, so a displacement of −4 gives base − 4 (mod 2^ADDR_W).
- R4: With `in_has_base` = 0 the base term is zero, and with `in_has_idx` = 0 the index term is zero, whatever is on `in_base` / `in_idx`.
- R5: For `in_kind` = 0 (address-only), the output beat has `out_reg_we` = 1, `out_reg_data` = `out_addr` and `out_reg_idx` = `in_dst`, with `out_mem_req` = 0. `in_write`, `in_size` and `in_other_mem` have no effect on it.
- R6: For a legal `in_kind` = 1 (memory-access) request, the output beat has `out_mem_req` = 1, `out_reg_we` = 0, `out_mem_we` = `in_write`, and `out_mem_bytes` one-hot from `in_size`: 2'b00 → 3'b001 (1 byte), 2'b01 → 3'b010 (2 bytes), 2'b10 → 3'b100 (4 bytes).
- R7: A memory-access request with `in_size` = 2'b11 yields `out_illegal` = 1, `out_mem_req` = 0, `out_reg_we` = 0.
- R8: A memory-access request with `in_other_mem` = 1 (both operands in memory) yields `out_illegal` = 1, `out_mem_req` = 0, `out_reg_we` = 0.
- R9: A request accepted on a clock edge (`in_valid` and `in_ready` high) appears with `out_valid` = 1 after that same edge. While `out_valid` = 1 and `out_ready` = 0, the beat and all its fields stay unchanged.
- R10: `in_ready` = 1 exactly when the output register is empty or `out_ready` = 1. Reset leaves `out_valid` = 0, and with it `out_reg_we`, `out_mem_req` and `out_mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle if valid |
| in_kind | input | 1 | 0 = address-only, 1 = memory access |
| in_write | input | 1 | Memory access is a write |
| in_other_mem | input | 1 | The other operand is also in memory |
| in_has_base | input | 1 | Base term present |
| in_base | input | ADDR_W | Base register value |
| in_has_idx | input | 1 | Index term present |
| in_idx | input | ADDR_W | Index register value |
| in_scale | input | 2 | Index scale code |
| in_disp | input | ADDR_W | Signed displacement |
| in_size | input | 2 | Memory operand width code |
| in_dst | input | REG_IDX_W | Destination register for address-only |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_addr | output | ADDR_W | Computed address |
| out_illegal | output | 1 | Request refused |
| out_reg_we | output | 1 | Register write-back of the address |
| out_reg_idx | output | REG_IDX_W | Write-back destination |
| out_reg_data | output | ADDR_W | Write-back value |
| out_mem_req | output | 1 | Memory request issued |
| out_mem_we | output | 1 | Memory request is a write |
| out_mem_bytes | output | 3 | One-hot operand width |

## Verification
The hardest case to reach from the ports is a stalled beat: a result held while `out_ready` is low, with a different valid request waiting on the input that must not be taken in or disturb the held fields. The bench holds `out_ready` low for several cycles on purpose and keeps new requests on the input during that time. It also runs a long stretch where `out_ready` and `in_valid` toggle pseudo-randomly, so that acceptance and hold interleave in many orders. Address wraparound is reached with base, index and displacement values near the top of the range, and a negative displacement with no base present.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic {
      EA_KIND_ADDR = 1'b0,
      EA_KIND_MEM  = 1'b1
   } ea_kind_e;

   typedef enum logic [1:0] {
      EA_SZ_BYTE = 2'b00,
      EA_SZ_HALF = 2'b01,
      EA_SZ_WORD = 2'b10,
      EA_SZ_RSVD = 2'b11
   } ea_size_e;

   localparam int EA_BYTES_W = 3;

   function automatic logic [EA_BYTES_W-1:0] ea_size_onehot(input ea_size_e sz);
      logic [EA_BYTES_W-1:0] oh;
      case (sz)
         EA_SZ_BYTE: oh = 3'b001;
         EA_SZ_HALF: oh = 3'b010;
         EA_SZ_WORD: oh = 3'b100;
         default:    oh = 3'b000;
      endcase
      return oh;
   endfunction

endpackage

// File: rtl/ea_term_sel.sv
module ea_term_sel #(
   parameter int ADDR_W         = 32,
   parameter int SCALE_BY_SHIFT = 1
) (
   input  logic              has_base,
   input  logic [ADDR_W-1:0] base_val,
   input  logic              has_idx,
   input  logic [ADDR_W-1:0] idx_val,
   input  logic [1:0]        scale_code,
   output logic [ADDR_W-1:0] base_term,
   output logic [ADDR_W-1:0] idx_term
);

   logic [ADDR_W-1:0] idx_masked;

   assign base_term  = has_base ? base_val : '0;
   assign idx_masked = has_idx  ? idx_val  : '0;

   generate
      if (SCALE_BY_SHIFT != 0) begin : g_shift
         assign idx_term = idx_masked << scale_code;
      end else begin : g_mult
         logic [ADDR_W-1:0] factor;
         assign factor   = ADDR_W'(1) << scale_code;
         assign idx_term = idx_masked * factor;
      end
   endgenerate

endmodule

// File: rtl/ea_sum3.sv
module ea_sum3 #(
   parameter int ADDR_W    = 32,
   parameter int CSA_FIRST = 1
) (
   input  logic [ADDR_W-1:0] term_a,
   input  logic [ADDR_W-1:0] term_b,
   input  logic [ADDR_W-1:0] term_c,
   output logic [ADDR_W-1:0] sum
);

   generate
      if (CSA_FIRST != 0) begin : g_csa
         logic [ADDR_W-1:0] part_s;
         logic [ADDR_W-1:0] part_c;
         assign part_s = term_a ^ term_b ^ term_c;
         assign part_c = ((term_a & term_b) | (term_a & term_c) | (term_b & term_c)) << 1;
         assign sum    = part_s + part_c;
      end else begin : g_chain
         assign sum = term_a + term_b + term_c;
      end
   endgenerate

endmodule

// File: rtl/ea_classify.sv
module ea_classify
   import ea_pkg::*;
(
   input  ea_kind_e              kind,
   input  logic                  write,
   input  logic                  other_mem,
   input  ea_size_e              size,
   output logic                  illegal,
   output logic                  reg_we,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [EA_BYTES_W-1:0] mem_bytes
);

   logic is_mem;

   always_comb begin
      is_mem    = (kind == EA_KIND_MEM);
      illegal   = is_mem && (other_mem || (size == EA_SZ_RSVD));
      reg_we    = !is_mem;
      mem_req   = is_mem && !illegal;
      mem_we    = mem_req && write;
      mem_bytes = mem_req ? ea_size_onehot(size) : '0;
   end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
   import ea_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int REG_IDX_W      = 3,
   parameter int SCALE_BY_SHIFT = 1,
   parameter int CSA_FIRST      = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic                 in_kind,
   input  logic                 in_write,
   input  logic                 in_other_mem,
   input  logic                 in_has_base,
   input  logic [ADDR_W-1:0]    in_base,
   input  logic                 in_has_idx,
   input  logic [ADDR_W-1:0]    in_idx,
   input  logic [1:0]           in_scale,
   input  logic [ADDR_W-1:0]    in_disp,
   input  logic [1:0]           in_size,
   input  logic [REG_IDX_W-1:0] in_dst,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [ADDR_W-1:0]    out_addr,
   output logic                 out_illegal,
   output logic                 out_reg_we,
   output logic [REG_IDX_W-1:0] out_reg_idx,
   output logic [ADDR_W-1:0]    out_reg_data,
   output logic                 out_mem_req,
   output logic                 out_mem_we,
   output logic [2:0]           out_mem_bytes
);

   localparam int MAX_SHIFT = 3;

   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
         $error("ea_gen: ADDR_W must lie in 8..64");
      end
      if (REG_IDX_W < 1) begin : g_bad_idx_w
         $error("ea_gen: REG_IDX_W must be at least 1");
      end
      if (ADDR_W <= MAX_SHIFT) begin : g_bad_shift
         $error("ea_gen: ADDR_W too narrow for the largest scale");
      end
   endgenerate

   logic [ADDR_W-1:0]     base_term;
   logic [ADDR_W-1:0]     idx_term;
   logic [ADDR_W-1:0]     ea_sum;
   logic                  c_illegal;
   logic                  c_reg_we;
   logic                  c_mem_req;
   logic                  c_mem_we;
   logic [EA_BYTES_W-1:0] c_bytes;
   logic                  take;

   ea_term_sel #(
      .ADDR_W         (ADDR_W),
      .SCALE_BY_SHIFT (SCALE_BY_SHIFT)
   ) u_terms (
      .has_base   (in_has_base),
      .base_val   (in_base),
      .has_idx    (in_has_idx),
      .idx_val    (in_idx),
      .scale_code (in_scale),
      .base_term  (base_term),
      .idx_term   (idx_term)
   );

   ea_sum3 #(
      .ADDR_W    (ADDR_W),
      .CSA_FIRST (CSA_FIRST)
   ) u_sum (
      .term_a (base_term),
      .term_b (idx_term),
      .term_c (in_disp),
      .sum    (ea_sum)
   );

   ea_classify u_cls (
      .kind      (ea_kind_e'(in_kind)),
      .write     (in_write),
      .other_mem (in_other_mem),
      .size      (ea_size_e'(in_size)),
      .illegal   (c_illegal),
      .reg_we    (c_reg_we),
      .mem_req   (c_mem_req),
      .mem_we    (c_mem_we),
      .mem_bytes (c_bytes)
   );

   logic                  q_valid;
   logic [ADDR_W-1:0]     q_addr;
   logic                  q_illegal;
   logic                  q_reg_we;
   logic [REG_IDX_W-1:0]  q_dst;
   logic                  q_mem_req;
   logic                  q_mem_we;
   logic [EA_BYTES_W-1:0] q_bytes;

   assign in_ready = !q_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid   <= 1'b0;
         q_addr    <= '0;
         q_illegal <= 1'b0;
         q_reg_we  <= 1'b0;
         q_dst     <= '0;
         q_mem_req <= 1'b0;
         q_mem_we  <= 1'b0;
         q_bytes   <= '0;
      end else if (in_ready) begin
         q_valid <= in_valid;
         if (take) begin
            q_addr    <= ea_sum;
            q_illegal <= c_illegal;
            q_reg_we  <= c_reg_we;
            q_dst     <= in_dst;
            q_mem_req <= c_mem_req;
            q_mem_we  <= c_mem_we;
            q_bytes   <= c_bytes;
         end
      end
   end

   assign out_valid     = q_valid;
   assign out_addr      = q_addr;
   assign out_illegal   = q_valid && q_illegal;
   assign out_reg_we    = q_valid && q_reg_we;
   assign out_reg_idx   = q_dst;
   assign out_reg_data  = out_reg_we ? q_addr : '0;
   assign out_mem_req   = q_valid && q_mem_req;
   assign out_mem_we    = q_valid && q_mem_we;
   assign out_mem_bytes = q_valid ? q_bytes : '0;

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
   parameter int ADDR_W    = 32,
   parameter int REG_IDX_W = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [ADDR_W-1:0]    out_addr,
   input logic                 out_illegal,
   input logic                 out_reg_we,
   input logic [REG_IDX_W-1:0] out_reg_idx,
   input logic [ADDR_W-1:0]    out_reg_data,
   input logic                 out_mem_req,
   input logic                 out_mem_we,
   input logic [2:0]           out_mem_bytes
);

   a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_illegal)
         && $stable(out_reg_we) && $stable(out_reg_idx) && $stable(out_mem_req)
         && $stable(out_mem_we) && $stable(out_mem_bytes)));

   a_r10_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   a_r5_one_action: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_reg_we && out_mem_req));

   a_r5_wb_value: assert property (@(posedge clk) disable iff (!rst_n)
      out_reg_we |-> (out_reg_data == out_addr));

   a_r6_width_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      out_mem_req |-> $onehot0(out_mem_bytes) && (out_mem_bytes != 3'b000));

   a_r6_write_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      out_mem_we |-> out_mem_req);

   a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (!out_reg_we && !out_mem_req && out_valid));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($countones({out_reg_we, out_mem_req, out_mem_we}) == 0));

endmodule

bind ea_gen ea_gen_chk #(
   .ADDR_W    (ADDR_W),
   .REG_IDX_W (REG_IDX_W)
) u_ea_gen_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_ready      (in_ready),
   .out_valid     (out_valid),
   .out_ready     (out_ready),
   .out_addr      (out_addr),
   .out_illegal   (out_illegal),
   .out_reg_we    (out_reg_we),
   .out_reg_idx   (out_reg_idx),
   .out_reg_data  (out_reg_data),
   .out_mem_req   (out_mem_req),
   .out_mem_we    (out_mem_we),
   .out_mem_bytes (out_mem_bytes)
);

// File: tb/test_ea_gen.sv
`timescale 1ns/100ps
module test_ea_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        in_kind = 1'b0;
   logic        in_write = 1'b0;
   logic        in_other_mem = 1'b0;
   logic        in_has_base = 1'b0;
   logic [31:0] in_base = '0;
   logic        in_has_idx = 1'b0;
   logic [31:0] in_idx = '0;
   logic [1:0]  in_scale = '0;
   logic [31:0] in_disp = '0;
   logic [1:0]  in_size = '0;
   logic [2:0]  in_dst = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_addr;
   logic        out_illegal;
   logic        out_reg_we;
   logic [2:0]  out_reg_idx;
   logic [31:0] out_reg_data;
   logic        out_mem_req;
   logic        out_mem_we;
   logic [2:0]  out_mem_bytes;

   int checks = 0;
   int fails  = 0;

   // reference model state: the beat expected in the output register
   bit          e_valid = 0;
   logic [31:0] e_addr;
   bit          e_ill, e_rwe, e_mreq, e_mwe;
   logic [2:0]  e_bytes, e_dst;

   always #2.5 clk = ~clk;

   ea_gen i_ea_gen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_kind(in_kind), .in_write(in_write), .in_other_mem(in_other_mem),
      .in_has_base(in_has_base), .in_base(in_base), .in_has_idx(in_has_idx),
      .in_idx(in_idx), .in_scale(in_scale), .in_disp(in_disp), .in_size(in_size),
      .in_dst(in_dst), .out_valid(out_valid), .out_ready(out_ready),
      .out_addr(out_addr), .out_illegal(out_illegal), .out_reg_we(out_reg_we),
      .out_reg_idx(out_reg_idx), .out_reg_data(out_reg_data),
      .out_mem_req(out_mem_req), .out_mem_we(out_mem_we), .out_mem_bytes(out_mem_bytes)
   );

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_out(string tag);
      chk({tag, " R9"}, "out_valid", out_valid, e_valid);
      if (e_valid) begin
         chk({tag, " R1"}, "out_addr", out_addr, e_addr);
         chk({tag, " R8"}, "out_illegal", out_illegal, e_ill);
         chk({tag, " R5"}, "out_reg_we", out_reg_we, e_rwe);
         chk({tag, " R6"}, "out_mem_req", out_mem_req, e_mreq);
         chk({tag, " R6"}, "out_mem_we", out_mem_we, e_mwe);
         chk({tag, " R6"}, "out_mem_bytes", out_mem_bytes, e_bytes);
         if (e_rwe) begin
            chk({tag, " R5"}, "out_reg_data", out_reg_data, e_addr);
            chk({tag, " R5"}, "out_reg_idx", out_reg_idx, e_dst);
         end
      end else begin
         chk({tag, " R10"}, "idle side effects",
             {out_reg_we, out_mem_req, out_mem_we}, 3'b000);
      end
   endtask

   // one clock: drive at negedge, predict, check at next negedge
   task automatic cyc(string tag, bit v, bit kind, bit wr, bit om,
                      bit hb, logic [31:0] b, bit hi, logic [31:0] ix,
                      logic [1:0] sc, logic [31:0] d, logic [1:0] sz,
                      logic [2:0] dst, bit ordy);
      bit          rdy;
      longint      fac;
      logic [63:0] s;
      in_valid = v; in_kind = kind; in_write = wr; in_other_mem = om;
      in_has_base = hb; in_base = b; in_has_idx = hi; in_idx = ix;
      in_scale = sc; in_disp = d; in_size = sz; in_dst = dst; out_ready = ordy;
      #1;
      rdy = !e_valid || ordy;
      chk({tag, " R10"}, "in_ready", in_ready, rdy);
      if (rdy) begin
         e_valid = v;
         if (v) begin
            case (sc)
               2'd0: fac = 1;
               2'd1: fac = 2;
               2'd2: fac = 4;
               default: fac = 8;
            endcase
            s = (hb ? {32'd0, b} : 64'd0) + (hi ? {32'd0, ix} : 64'd0) * fac + {32'd0, d};
            e_addr = s[31:0];
            e_ill  = kind && (om || sz == 2'b11);
            e_rwe  = !kind;
            e_mreq = kind && !e_ill;
            e_mwe  = e_mreq && wr;
            e_bytes = !e_mreq ? 3'b000 : (sz == 2'b00) ? 3'b001 : (sz == 2'b01) ? 3'b010 : 3'b100;
            e_dst  = dst;
         end
      end
      @(negedge clk);
      compare_out(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset", "out_valid", out_valid, 0);
      chk("R10 reset", "in_ready", in_ready, 1);
      chk("R10 reset", "side effects", {out_reg_we, out_mem_req, out_mem_we}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 basic three-term sum, R2 each scale code
      cyc("R1 sum", 1, 0, 0, 0, 1, 32'h1000, 1, 32'h10, 2'd0, 32'h4, 2'd0, 3'd1, 1);
      cyc("R2 x2",  1, 0, 0, 0, 1, 32'h1000, 1, 32'h10, 2'd1, 32'h0, 2'd0, 3'd2, 1);
      cyc("R2 x4",  1, 0, 0, 0, 1, 32'h1000, 1, 32'h10, 2'd2, 32'h0, 2'd0, 3'd3, 1);
      cyc("R2 x8",  1, 0, 0, 0, 1, 32'h1000, 1, 32'h10, 2'd3, 32'h0, 2'd0, 3'd4, 1);
      // R3 negative displacement
      cyc("R3 neg", 1, 1, 0, 0, 1, 32'h2000, 0, 32'h0, 2'd0, 32'hFFFF_FFFC, 2'd2, 3'd0, 1);
      cyc("R3 neg only", 1, 0, 0, 0, 0, 32'h0, 0, 32'h0, 2'd0, 32'hFFFF_FFF0, 2'd0, 3'd5, 1);
      // R4 absent terms with nonzero values
      cyc("R4 no base", 1, 0, 0, 0, 0, 32'hDEAD_BEEF, 1, 32'h3, 2'd3, 32'h1, 2'd0, 3'd6, 1);
      cyc("R4 no idx",  1, 0, 0, 0, 1, 32'h40, 0, 32'hFFFF_FFFF, 2'd3, 32'h8, 2'd0, 3'd7, 1);
      // R1 wraparound
      cyc("R1 wrap", 1, 0, 0, 0, 1, 32'hFFFF_FFF0, 1, 32'hF000_0000, 2'd3, 32'h7FFF_FFFF, 2'd0, 3'd1, 1);
      // R5 address-only ignores write/size/other_mem
      cyc("R5 ignore", 1, 0, 1, 1, 1, 32'h100, 1, 32'h2, 2'd1, 32'h0, 2'd3, 3'd2, 1);
      // R6 sizes and direction
      cyc("R6 byte rd", 1, 1, 0, 0, 1, 32'h300, 0, 32'h0, 2'd0, 32'h1, 2'd0, 3'd0, 1);
      cyc("R6 half wr", 1, 1, 1, 0, 1, 32'h300, 1, 32'h1, 2'd1, 32'h2, 2'd1, 3'd0, 1);
      cyc("R6 word wr", 1, 1, 1, 0, 1, 32'h300, 1, 32'h1, 2'd2, 32'h3, 2'd2, 3'd0, 1);
      // R7 reserved size, R8 two memory operands
      cyc("R7 rsvd size", 1, 1, 1, 0, 1, 32'h500, 0, 32'h0, 2'd0, 32'h0, 2'd3, 3'd0, 1);
      cyc("R8 mem2mem", 1, 1, 1, 1, 1, 32'h600, 0, 32'h0, 2'd0, 32'h0, 2'd2, 3'd0, 1);
      cyc("R8 mem2mem rd", 1, 1, 0, 1, 0, 32'h0, 1, 32'h7, 2'd2, 32'h0, 2'd0, 3'd0, 1);
      // R9 hold under backpressure with new requests waiting
      cyc("R9 load", 1, 1, 1, 0, 1, 32'hABC0, 0, 32'h0, 2'd0, 32'h4, 2'd2, 3'd0, 0);
      for (int k = 0; k < 4; k++)
         cyc("R9 hold", 1, 0, 0, 0, 1, 32'h1111 * k, 1, 32'h5, 2'd1, 32'h9, 2'd0, 3'd3, 0);
      cyc("R9 release", 1, 0, 0, 0, 1, 32'h7000, 0, 32'h0, 2'd0, 32'h0, 2'd0, 3'd4, 1);
      cyc("R10 drain", 0, 0, 0, 0, 0, 32'h0, 0, 32'h0, 2'd0, 32'h0, 2'd0, 3'd0, 1);

      // mixed pseudo-random traffic
      for (int n = 0; n < 600; n++) begin
         logic [31:0] rv;
         rv = $urandom;
         cyc("R1 rand", rv[0] | rv[1], rv[2], rv[3], (rv[4] & rv[5]), rv[6], $urandom,
             rv[7], $urandom, rv[9:8], $urandom, rv[11:10], rv[14:12], rv[15] | rv[16]);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule